// File: doc/BRIEF.md
# Cascaded Column Data Receiver

This block is the input stage of one column driver in a chain of identical drivers that share one pixel data bus. A shift strobe moves pixel data into a column register, 4 or 8 columns per transfer, but only while the stage's enable input is low and its columns are not yet full. Once the last column is filled, the stage drops its enable output. That output feeds the enable input of the next stage, so the shared bus fills the stages one after another.

A rising edge on the line strobe copies the column register to a parallel line word and raises a one-cycle valid flag. The same edge clears the register and the fill pointer and raises the enable output again, so the chain is ready for the next line. A direction input picks which of the two enable pin pairs is the input and which is the output. It also sets whether columns fill from index 0 upward or from the top index downward. Both strobes are plain inputs sampled in the system clock domain, and their edges are detected there.

Top module: `col_rx_cascade`

## Requirements
- R1: While reset is asserted and just after it, `line_o` is all zeros, `line_valid_o` is low, and both `ena_a_o` and `ena_b_o` are high.
- R2: A transfer is captured only on a falling edge of `shift_clk_i`, where the input is high in one clock and low in the next. It uses the `pix_i` value present in the low cycle. A rising edge, or a falling edge while the active enable input is high, leaves the register and the pointer unchanged.
- R3: With `width_sel_i`=1, one transfer writes 8 columns, and `pix_i` bit k goes to the k-th next column in fill order. 20 transfers fill the default 160 columns.
- R4: With `width_sel_i`=0, one transfer writes 4 columns from `pix_i[3:0]`, and `pix_i[7:4]` has no effect. 40 transfers fill 160 columns.
- R5: With `dir_i`=0, `ena_a_i` is the enable input and `ena_b_o` is the enable output, while `ena_a_o` is held high and `ena_b_i` is ignored. Columns fill upward from index 0: transfer n, bit k goes to column n*W+k.
- R6: With `dir_i`=1, `ena_b_i` is the enable input and `ena_a_o` is the enable output, while `ena_b_o` is held high and `ena_a_i` is ignored. Columns fill downward from the top index: transfer n, bit k goes to column NUM_COLS-1-n*W-k.
- R7: The enable output is high while the stage is not full. It goes low one clock after the transfer that fills the last column, and further transfers are ignored until the next line strobe.
- R8: A rising edge of `latch_i` loads `line_o` with the column register one clock later and holds `line_valid_o` high for exactly that one clock. At that edge the register is cleared, so columns not written in the next line read 0, and the enable output returns high.
- R9: If a line strobe rising edge and a shift falling edge fall on the same clock, the line strobe wins and the transfer is dropped.
- R10: `line_o` changes only in the cycle where `line_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_clk_i | input | 1 | Shift strobe; a transfer is taken on its falling edge |
| latch_i | input | 1 | Line strobe; acts on its rising edge |
| width_sel_i | input | 1 | 1 selects 8-bit transfers, 0 selects 4-bit transfers |
| dir_i | input | 1 | Fill direction and enable pin role select |
| pix_i | input | BUS_W | Pixel data bus |
| ena_a_i | input | 1 | Enable input A (active low), used when dir_i=0 |
| ena_b_i | input | 1 | Enable input B (active low), used when dir_i=1 |
| ena_a_o | output | 1 | Enable output A; carries the chain enable when dir_i=1 |
| ena_b_o | output | 1 | Enable output B; carries the chain enable when dir_i=0 |
| line_o | output | NUM_COLS | Parallel line word |
| line_valid_o | output | 1 | One-cycle strobe marking a new line word |

## Verification
Two situations are hard to reach from the ports. The first is a line strobe edge that lands in the same clock as a shift falling edge. The bench reaches it by raising the shift strobe one cycle ahead and then lowering it in the same cycle that the line strobe rises. A following empty line then shows that the colliding data never reached the register. The second is the overfull condition: the bench pushes one extra transfer after every full line and confirms that the line word carries only the data that fits. Every combination of fill direction and bus width is swept with arithmetic data patterns. The pins that should be ignored are driven opposite to the active ones.

// File: rtl/col_rx_pkg.sv
package col_rx_pkg;
  typedef enum logic {
    FILL_UP   = 1'b0,
    FILL_DOWN = 1'b1
  } fill_dir_e;

  typedef enum logic {
    BUS_HALF = 1'b0,
    BUS_FULL = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/col_rx_edge.sv
module col_rx_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sig_i & ~sig_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & sig_q;
    end
  endgenerate
endmodule

// File: rtl/col_rx_ptr.sv
module col_rx_ptr #(
  parameter int NUM_COLS = 160,
  parameter int PTR_W    = $clog2(NUM_COLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] step_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_COLS);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (adv_i)   ptr_q <= ptr_q + step_i;
  end

  assign ptr_o  = ptr_q;
  assign full_o = (ptr_q >= LIMIT);
endmodule

// File: rtl/col_rx_reg.sv
module col_rx_reg #(
  parameter int NUM_COLS = 160,
  parameter int BUS_W    = 8,
  parameter int PTR_W    = $clog2(NUM_COLS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                wr_i,
  input  logic                down_i,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic [PTR_W-1:0]    lanes_i,
  input  logic [BUS_W-1:0]    pix_i,
  output logic [NUM_COLS-1:0] cols_o
);
  localparam int SEL_W = $clog2(BUS_W);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [PTR_W-1:0] pos;
    logic [PTR_W-1:0] diff;
    logic             hit;
    logic             col_q;

    // position of this column in fill order
    assign pos  = down_i ? PTR_W'(NUM_COLS - 1 - c) : PTR_W'(c);
    assign diff = pos - ptr_i;
    assign hit  = (pos >= ptr_i) && (diff < lanes_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         col_q <= 1'b0;
      else if (clear_i)    col_q <= 1'b0;
      else if (wr_i && hit) col_q <= pix_i[diff[SEL_W-1:0]];
    end

    assign cols_o[c] = col_q;
  end
endmodule

// File: rtl/col_rx_cascade.sv
module col_rx_cascade
  import col_rx_pkg::*;
#(
  parameter int NUM_COLS = 160,
  parameter int BUS_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_clk_i,
  input  logic                latch_i,
  input  logic                width_sel_i,
  input  logic                dir_i,
  input  logic [BUS_W-1:0]    pix_i,
  input  logic                ena_a_i,
  input  logic                ena_b_i,
  output logic                ena_a_o,
  output logic                ena_b_o,
  output logic [NUM_COLS-1:0] line_o,
  output logic                line_valid_o
);
  localparam int PTR_W = $clog2(NUM_COLS + 1);

  fill_dir_e        fill_dir;
  bus_mode_e        bus_mode;
  logic             shift_fall;
  logic             latch_rise;
  logic             ena_in;
  logic             full;
  logic             capture;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] lanes;
  logic [NUM_COLS-1:0] cols;
  logic [NUM_COLS-1:0] line_q;
  logic             valid_q;

  assign fill_dir = fill_dir_e'(dir_i);
  assign bus_mode = bus_mode_e'(width_sel_i);

  col_rx_edge #(.RISE(1'b0)) u_shift_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (shift_clk_i),
    .edge_o(shift_fall)
  );

  col_rx_edge #(.RISE(1'b1)) u_latch_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (latch_i),
    .edge_o(latch_rise)
  );

  assign ena_in  = (fill_dir == FILL_DOWN) ? ena_b_i : ena_a_i;
  assign lanes   = (bus_mode == BUS_FULL) ? PTR_W'(BUS_W) : PTR_W'(BUS_W / 2);
  // line strobe takes priority over a colliding transfer
  assign capture = shift_fall & ~ena_in & ~full & ~latch_rise;

  col_rx_ptr #(.NUM_COLS(NUM_COLS), .PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(latch_rise),
    .adv_i  (capture),
    .step_i (lanes),
    .ptr_o  (ptr),
    .full_o (full)
  );

  col_rx_reg #(.NUM_COLS(NUM_COLS), .BUS_W(BUS_W), .PTR_W(PTR_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(latch_rise),
    .wr_i   (capture),
    .down_i (fill_dir == FILL_DOWN),
    .ptr_i  (ptr),
    .lanes_i(lanes),
    .pix_i  (pix_i),
    .cols_o (cols)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= latch_rise;
      if (latch_rise) line_q <= cols;
    end
  end

  assign line_o       = line_q;
  assign line_valid_o = valid_q;
  assign ena_a_o      = (fill_dir == FILL_DOWN) ? ~full : 1'b1;
  assign ena_b_o      = (fill_dir == FILL_DOWN) ? 1'b1 : ~full;
endmodule

// File: rtl/col_rx_cascade_chk.sv
module col_rx_cascade_chk #(
  parameter int NUM_COLS = 160,
  parameter int BUS_W    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                shift_clk_i,
  input logic                latch_i,
  input logic                width_sel_i,
  input logic                dir_i,
  input logic [BUS_W-1:0]    pix_i,
  input logic                ena_a_i,
  input logic                ena_b_i,
  input logic                ena_a_o,
  input logic                ena_b_o,
  input logic [NUM_COLS-1:0] line_o,
  input logic                line_valid_o
);
  AST_SIDE_A_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i |-> ena_a_o); // R5
  AST_SIDE_B_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i |-> ena_b_o); // R6
  AST_FULL_AFTER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ena_a_o & ena_b_o) && $stable(dir_i)) |-> ($past(shift_clk_i, 2) && !$past(shift_clk_i))); // R7
  AST_LATCH_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_i) |=> line_valid_o); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |=> !line_valid_o); // R8
  AST_REARM_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> (ena_a_o && ena_b_o)); // R8
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> line_valid_o); // R10
endmodule

bind col_rx_cascade col_rx_cascade_chk #(.NUM_COLS(NUM_COLS), .BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_clk_i (shift_clk_i),
  .latch_i     (latch_i),
  .width_sel_i (width_sel_i),
  .dir_i       (dir_i),
  .pix_i       (pix_i),
  .ena_a_i     (ena_a_i),
  .ena_b_i     (ena_b_i),
  .ena_a_o     (ena_a_o),
  .ena_b_o     (ena_b_o),
  .line_o      (line_o),
  .line_valid_o(line_valid_o)
);

// File: tb/col_rx_cascade_tb.sv
module col_rx_cascade_tb;
  localparam int NCOL = 160;
  localparam int BW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            shf = 1'b0;
  logic            lat = 1'b0;
  logic            wid = 1'b1;
  logic            dir = 1'b0;
  logic [BW-1:0]   pix = '0;
  logic            ena_a_i = 1'b0;
  logic            ena_b_i = 1'b1;
  logic            ena_a_o, ena_b_o, line_valid;
  logic [NCOL-1:0] line;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [NCOL-1:0] exp_reg = '0;
  logic [NCOL-1:0] exp_line = '0;
  int exp_ptr = 0;

  always #2 clk = ~clk;

  col_rx_cascade #(.NUM_COLS(NCOL), .BUS_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_clk_i(shf), .latch_i(lat),
    .width_sel_i(wid), .dir_i(dir), .pix_i(pix),
    .ena_a_i(ena_a_i), .ena_b_i(ena_b_i),
    .ena_a_o(ena_a_o), .ena_b_o(ena_b_o),
    .line_o(line), .line_valid_o(line_valid)
  );

  task automatic chk(input string req, input logic [NCOL-1:0] act, input logic [NCOL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected effect of one transfer carrying d
  task automatic model_put(input logic [BW-1:0] d);
    logic ein;
    int w;
    ein = dir ? ena_b_i : ena_a_i;
    w = wid ? BW : BW / 2;
    if (!ein && exp_ptr < NCOL) begin
      for (int k = 0; k < w; k++) begin
        int col;
        col = dir ? (NCOL - 1 - exp_ptr - k) : (exp_ptr + k);
        exp_reg[col] = d[k];
      end
      exp_ptr += w;
    end
  endtask

  task automatic put(input logic [BW-1:0] d);
    @(negedge clk); pix = d; shf = 1'b1;
    @(negedge clk); shf = 1'b0;
    @(negedge clk);
    model_put(d);
  endtask

  task automatic check_ena(input string req);
    logic o;
    o = (exp_ptr < NCOL);
    chk(req, NCOL'(dir ? ena_a_o : ena_b_o), NCOL'(o));
    chk(req, NCOL'(dir ? ena_b_o : ena_a_o), NCOL'(1'b1));
  endtask

  task automatic do_latch(input string req);
    @(negedge clk); lat = 1'b1;
    @(negedge clk);
    chk({req, " R8 valid"}, NCOL'(line_valid), NCOL'(1'b1));
    chk({req, " R8 line"}, line, exp_reg);
    exp_line = exp_reg; exp_reg = '0; exp_ptr = 0;
    check_ena({req, " R8 rearm"});
    lat = 1'b0;
    @(negedge clk);
    chk({req, " R8 single"}, NCOL'(line_valid), NCOL'(1'b0));
    chk({req, " R10 hold"}, line, exp_line);
  endtask

  task automatic run_fill(input logic d_sel, input logic w_sel, input int seed, input string req);
    int n;
    dir = d_sel; wid = w_sel;
    ena_a_i = d_sel; ena_b_i = ~d_sel;
    n = NCOL / (w_sel ? BW : BW / 2);
    for (int i = 0; i < n; i++) begin
      put(BW'((i * seed + (i >> 1) + 3) & 8'hff));
      check_ena({req, " R7 ena"});
    end
    put(8'ha5); // beyond full
    check_ena({req, " R7 full ignore"});
    do_latch(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 line", line, '0);
    chk("R1 valid", NCOL'(line_valid), '0);
    chk("R1 ena", NCOL'({ena_a_o, ena_b_o}), NCOL'(2'b11));
    rst_n = 1'b1;
    @(negedge clk);

    run_fill(1'b0, 1'b1, 37, "R3 R5 up byte");
    run_fill(1'b1, 1'b0, 53, "R4 R6 down nibble");
    run_fill(1'b0, 1'b0, 11, "R4 R5 up nibble");
    run_fill(1'b1, 1'b1, 201, "R3 R6 down byte");

    // wrong pin low, active pin high: nothing taken
    dir = 1'b0; wid = 1'b1; ena_a_i = 1'b1; ena_b_i = 1'b0;
    for (int i = 0; i < 4; i++) put(BW'(8'h3c + i));
    check_ena("R2 R5 inactive");
    do_latch("R2 R5 inactive");
    dir = 1'b1; ena_a_i = 1'b0; ena_b_i = 1'b1;
    for (int i = 0; i < 4; i++) put(BW'(8'hc3 - i));
    do_latch("R2 R6 inactive");

    // data at rising edge differs from data at falling edge
    dir = 1'b0; ena_a_i = 1'b0; ena_b_i = 1'b1; wid = 1'b1;
    @(negedge clk); pix = 8'hff; shf = 1'b1;
    @(negedge clk); pix = 8'h81; shf = 1'b0;
    @(negedge clk);
    model_put(8'h81);
    do_latch("R2 falling sample");

    // partial line then collision of strobes
    for (int i = 0; i < 3; i++) put(BW'(8'h5a ^ i));
    @(negedge clk); pix = 8'hee; shf = 1'b1;
    @(negedge clk); shf = 1'b0; lat = 1'b1;
    @(negedge clk);
    chk("R9 line", line, exp_reg);
    chk("R9 valid", NCOL'(line_valid), NCOL'(1'b1));
    exp_line = exp_reg; exp_reg = '0; exp_ptr = 0;
    lat = 1'b0;
    @(negedge clk);
    check_ena("R9 rearm");
    do_latch("R9 dropped");

    // held line while new data streams in
    for (int i = 0; i < 5; i++) put(BW'(8'h17 * i));
    chk("R10 stable", line, exp_line);
    do_latch("R8 partial clear");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule